// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when an analog-to-digital conversion begins. A 3-bit source code picks the trigger. The possible triggers are an active-low external pin, an overflow strobe from one of two timers, a single software request, free-running software conversion, or a strobe from a programmable logic array. When the selected trigger fires, the block issues a one-cycle start pulse. It then holds a busy flag for the duration of the conversion and emits a done pulse when the conversion ends.

A shared enable input blocks every source except free-running conversion. The external pin is shared with other pin functions, so it is synchronised and edge-detected but only acts when its own code is selected. A falling edge on that pin can interrupt a running conversion. The current conversion is then dropped and a fresh one starts.

The converter is modelled as a fixed-latency busy window of `CONV_CYCLES` clock cycles.

Top module: `adc_start_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, start_o, busy_o and done_o are all low.
- R2: mode_i selects the trigger source with this encoding: 0 external pin, 1 timer 1 overflow, 2 timer 0 overflow, 3 single software request, 4 free-running conversion, 5 logic-array strobe. Codes 6 and 7 never produce a start pulse.
- R3: With mode_i = 0 and enable_i high, a falling edge on ext_n_i causes exactly one start pulse. If ext_n_i is first sampled low at clock edge k after having been sampled high, start_o is high in the cycle that follows edge k+2 (two synchronizer stages plus edge register).
- R4: When mode_i is not 0, edges on ext_n_i have no effect on start_o.
- R5: A selected external falling edge that arrives while busy_o is high issues a new start pulse. busy_o stays high throughout. No done pulse is produced for the abandoned conversion, and done_o follows the new start after the full window.
- R6: With enable_i low, no start pulse is issued in modes 0, 1, 2, 3 and 5. Mode 4 is unaffected by enable_i.
- R7: In modes 1, 2, 3 and 5, the trigger input being high in a cycle in which busy_o and start_o are both low gives start_o high in the next cycle. The trigger is ignored while busy_o or start_o is high.
- R8: After a start pulse in cycle t, busy_o is high in cycles t+1 to t+CONV_CYCLES, and done_o is a single-cycle pulse in cycle t+CONV_CYCLES+1.
- R9: In mode 4, a start is issued whenever busy_o and start_o are both low. Each later start therefore comes one cycle after done_o, giving a start period of CONV_CYCLES+2 cycles.
- R10: start_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Trigger source code |
| enable_i | input | 1 | Trigger enable (does not gate mode 4) |
| ext_n_i | input | 1 | External start pin, active low, asynchronous |
| tmr1_ovf_i | input | 1 | Timer 1 overflow strobe |
| tmr0_ovf_i | input | 1 | Timer 0 overflow strobe |
| sw_req_i | input | 1 | Single software conversion request strobe |
| array_trig_i | input | 1 | Programmable logic array trigger strobe |
| start_o | output | 1 | One-cycle conversion start pulse |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle conversion complete pulse |

## Verification
The bench toggles the external pin while a non-pin source is selected. A design that let the shared pin through, as a pin hard-wired to the converter would, starts unwanted conversions. The bench also drops the pin again mid-conversion. A design that ignored the restart would keep the old done time, and one that finished the aborted conversion would emit an extra done pulse.

Free-running mode is run with enable low and its start spacing is measured. A design that gated it, or whose restart is off by a cycle, breaks that period. Random strobes that arrive while a conversion is busy, and the two unused codes, catch designs that queue requests or decode a spare code into a source.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
  typedef enum logic [2:0] {
    SRC_EXT   = 3'd0,
    SRC_TMR1  = 3'd1,
    SRC_TMR0  = 3'd2,
    SRC_SW    = 3'd3,
    SRC_CONT  = 3'd4,
    SRC_ARRAY = 3'd5
  } src_e;

  localparam int unsigned NUM_SRC = 6;
endpackage

// File: rtl/adc_fall_detect.sv
module adc_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // idle level of the active-low pin is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  // R3
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
  import adc_start_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       enable_i,
  input  logic       idle_i,
  input  logic       fall_i,
  input  logic       tmr1_i,
  input  logic       tmr0_i,
  input  logic       sw_i,
  input  logic       array_i,
  output logic       trig_o
);
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] hit;

  always_comb begin
    req                 = '0;
    req[int'(SRC_EXT)]   = fall_i;
    req[int'(SRC_TMR1)]  = tmr1_i;
    req[int'(SRC_TMR0)]  = tmr0_i;
    req[int'(SRC_SW)]    = sw_i;
    req[int'(SRC_CONT)]  = 1'b1;
    req[int'(SRC_ARRAY)] = array_i;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    localparam bit UNGATED = (k == int'(SRC_CONT));
    localparam bit PREEMPT = (k == int'(SRC_EXT));
    logic sel;
    assign sel    = (mode_i == 3'(k));
    assign hit[k] = req[k] & sel
                  & (UNGATED ? 1'b1 : enable_i)
                  & (PREEMPT ? 1'b1 : idle_i);
  end

  assign trig_o = |hit;
endmodule

// File: rtl/adc_conv_window.sv
module adc_conv_window #(
  parameter int unsigned CONV_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      // a new start reloads even mid-window: old conversion is dropped
      cnt_q  <= LAST;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q && cnt_q == '0) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      if (busy_q) cnt_q <= cnt_q - 1'b1;
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R8
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
  import adc_start_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       enable_i,
  input  logic       ext_n_i,
  input  logic       tmr1_ovf_i,
  input  logic       tmr0_ovf_i,
  input  logic       sw_req_i,
  input  logic       array_trig_i,
  output logic       start_o,
  output logic       busy_o,
  output logic       done_o
);
  logic fall;
  logic trig;
  logic idle;
  logic start_q;

  adc_fall_detect #(.STAGES(SYNC_STAGES)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_n_i),
    .fall_o (fall)
  );

  assign idle = ~busy_o & ~start_q;

  adc_trig_select u_sel (
    .mode_i   (mode_i),
    .enable_i (enable_i),
    .idle_i   (idle),
    .fall_i   (fall),
    .tmr1_i   (tmr1_ovf_i),
    .tmr0_i   (tmr0_ovf_i),
    .sw_i     (sw_req_i),
    .array_i  (array_trig_i),
    .trig_o   (trig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= trig;
  end

  adc_conv_window #(.CONV_CYCLES(CONV_CYCLES)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign start_o = start_q;

  // R10
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R2
  spare_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(mode_i) <= 3'd5));
  // R6
  enable_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(enable_i) || $past(mode_i) == SRC_CONT));
  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && $past(mode_i) != SRC_EXT) |-> !$past(busy_o));
endmodule

// File: tb/sim_adc_start_ctrl.sv
`timescale 1ns/1ps
module sim_adc_start_ctrl;
  localparam int C = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode = 3'd7;
  logic       en = 1'b0, ext_n = 1'b1, t1 = 1'b0, t0 = 1'b0, sw = 1'b0, arr = 1'b0;
  logic       start_o, busy_o, done_o;

  int vec = 0, bad = 0, cyc = 0;
  int n_start = 0, n_done = 0, last_st = -1;
  bit per_on = 0;

  // reference state
  logic m_s1, m_s2, m_prev, m_start, m_busy, m_done;
  int   m_cnt;

  always #2 clk = ~clk;

  adc_start_ctrl #(.CONV_CYCLES(C), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .enable_i(en), .ext_n_i(ext_n),
    .tmr1_ovf_i(t1), .tmr0_ovf_i(t0), .sw_req_i(sw), .array_trig_i(arr),
    .start_o(start_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string start_tag(logic [2:0] md);
    case (md)
      3'd0:    return "R3";
      3'd4:    return "R9";
      3'd6, 3'd7: return "R2";
      default: return "R7";
    endcase
  endfunction

  function automatic bit want_trig(logic [2:0] md, bit e, bit fl, bit idle);
    case (md)
      3'd0: return e && fl;
      3'd1: return e && t1 && idle;
      3'd2: return e && t0 && idle;
      3'd3: return e && sw && idle;
      3'd4: return idle;
      3'd5: return e && arr && idle;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_s1 = 1; m_s2 = 1; m_prev = 1; m_start = 0; m_busy = 0; m_done = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    bit fl, tr;
    fl = m_prev && !m_s2;
    tr = want_trig(mode, en, fl, !m_busy && !m_start);
    if (m_start) begin
      m_cnt = C - 1; m_busy = 1; m_done = 0;
    end else if (m_busy && m_cnt == 0) begin
      m_busy = 0; m_done = 1;
    end else begin
      if (m_busy) m_cnt--;
      m_done = 0;
    end
    m_start = tr;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_n;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_ni) model_step(); else model_reset();
    @(negedge clk);
    cyc++;
    chk(start_o == m_start, start_tag(mode), "start_o", start_o, m_start);
    chk(busy_o == m_busy, "R8", "busy_o", busy_o, m_busy);
    chk(done_o == m_done, "R8", "done_o", done_o, m_done);
    n_start += int'(start_o);
    n_done  += int'(done_o);
    if (per_on && start_o) begin
      if (last_st >= 0) chk(cyc - last_st == C + 2, "R9", "start period", cyc - last_st, C + 2);
      last_st = cyc;
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    model_reset();
    steps(3);
    chk(!start_o && !busy_o && !done_o, "R1", "outputs in reset",
        {start_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    step();
    chk(!start_o && !busy_o && !done_o, "R1", "outputs after reset",
        {start_o, busy_o, done_o}, 0);

    // R4: pin toggles under timer-1 mode
    mode = 3'd1; en = 1; n_start = 0;
    for (int i = 0; i < 5; i++) begin
      ext_n = 0; steps(3); ext_n = 1; steps(3);
    end
    chk(n_start == 0, "R4", "starts from unselected pin", n_start, 0);

    // R2: spare codes with every strobe high
    mode = 3'd6; t1 = 1; t0 = 1; sw = 1; arr = 1; n_start = 0;
    steps(8); mode = 3'd7; steps(8);
    chk(n_start == 0, "R2", "starts from spare codes", n_start, 0);
    t1 = 0; t0 = 0; sw = 0; arr = 0;

    // R6: enable low blocks a selected pin edge
    mode = 3'd0; en = 0; n_start = 0;
    ext_n = 0; steps(4); ext_n = 1; steps(4);
    chk(n_start == 0, "R6", "starts with enable low", n_start, 0);

    // R3: pin edge latency, then R5 restart mid-conversion
    en = 1; n_start = 0; n_done = 0;
    ext_n = 0; steps(2);
    chk(start_o == 0, "R3", "start before latency", start_o, 0);
    step();
    chk(start_o == 1, "R3", "start at edge+2", start_o, 1);
    steps(1); ext_n = 1; steps(1); ext_n = 0; steps(3);
    chk(n_start == 2, "R5", "restart pulses", n_start, 2);
    chk(busy_o == 1, "R5", "busy across restart", busy_o, 1);
    steps(C + 4);
    chk(n_done == 1, "R5", "done pulses after restart", n_done, 1);
    ext_n = 1; steps(4);

    // R9: free-running with enable low
    mode = 3'd4; en = 0; per_on = 1; last_st = -1;
    steps(5 * (C + 2));
    per_on = 0; mode = 3'd7; steps(C + 3);

    // R7: software strobe while busy is dropped
    mode = 3'd3; en = 1; n_start = 0;
    sw = 1; step(); sw = 0; steps(3); sw = 1; step(); sw = 0; steps(C + 2);
    chk(n_start == 1, "R7", "starts from strobes incl. busy one", n_start, 1);

    // random mix
    void'($urandom(32'h5a17c0de));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39) == 0) mode = 3'($urandom_range(7));
      if ($urandom_range(29) == 0) en = ($urandom_range(4) != 0);
      if ($urandom_range(5) == 0) ext_n = ~ext_n;
      t1  = ($urandom_range(7) == 0);
      t0  = ($urandom_range(7) == 0);
      sw  = ($urandom_range(7) == 0);
      arr = ($urandom_range(7) == 0);
      step();
    end
    finish_run();
  end
endmodule